// File: doc/BRIEF.md
# Parallel Flash Bus Front End

This block is the device-side front end of an asynchronous parallel NOR-style flash bus, sampled on a fast on-chip clock. Five active-low strobes come in from the pins: chip select, output enable, write strobe, address-valid strobe and a pin-level device reset. Each passes through a two-flop synchroniser. The chip-select and write strobes also pass through a glitch filter. From the conditioned strobes the block puts every clock cycle into one of six bus operation classes and publishes that class.

The block holds an address that is taken when the address-valid strobe is released. It turns a completed bus write into a single-cycle record that carries the address and the data. It enables the read data path only during a bus read. It also tells an external program/erase engine when a pin reset has cut short an operation in progress.

The address and data pins are treated as quasi-static. They must stay stable from the strobe's falling edge until a few clocks after its rising edge, which covers the conditioning latency. The command interpreter and the storage array sit outside this block.

Top module: `nor_bus_front`

## Requirements
- R1: `op_o` carries one of six codes, checked in this priority order: pin reset low gives 0; chip select high gives 1 (standby), or 5 while `busy_i` is set; write strobe low with output enable high gives 3 (write); output enable low with write strobe high gives 4 is not used here, it gives 2 (read); address-valid low with write and output enables high gives 4 (address latch); any other combination gives 5 (output disable).
- R2: During a bus read `dq_oe_o` is 1 and `dq_o` equals `rd_data_i`.
- R3: Whenever output enable is high, `dq_oe_o` is 0.
- R4: While chip select is high, code 1 is reported only when `busy_i` is clear. While the engine is busy the code stays 5, and it moves to 1 once `busy_i` drops. The data bus is not driven in either case.
- R5: Pin reset low overrides every other strobe. It gives code 0, `dq_oe_o` at 0, and no write record, even if the write strobe toggles.
- R6: A rising edge of address-valid while chip select is low and pin reset is high loads `addr_i` into `lat_addr_o`.
- R7: A write phase is chip select and write strobe low with output enable high. When the first of the two strobes rises, exactly one `wr_valid_o` pulse is produced, with `wr_data_o` taken from `dq_i`. This holds whichever strobe rises first.
- R8: The write record's address is `addr_i` if address-valid is low when the write completes. Otherwise it is the held address `lat_addr_o`.
- R9: A low pulse on chip select or the write strobe that lasts fewer than `GLITCH` (default 3) consecutive clock samples produces no write. A pulse of exactly `GLITCH` samples does produce one.
- R10: When pin reset goes low while `busy_i` is set, `abort_o` pulses for exactly one clock, in a cycle that reports code 0. When `busy_i` is clear, no pulse is produced.
- R11: `wr_valid_o` never stays high for two consecutive cycles.
- R12: During system reset (`rst_n` low), `op_o` is 0 and `dq_oe_o`, `wr_valid_o` and `abort_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| ce_n_i | input | 1 | Chip select strobe, active low |
| oe_n_i | input | 1 | Output enable strobe, active low |
| we_n_i | input | 1 | Write strobe, active low |
| adv_n_i | input | 1 | Address-valid strobe, active low; address taken on release |
| prst_n_i | input | 1 | Pin-level device reset, active low |
| addr_i | input | AW (23) | Address pins |
| dq_i | input | DW (16) | Data pins, input side |
| rd_data_i | input | DW (16) | Read data supplied by the interpreter/array |
| busy_i | input | 1 | Program/erase engine busy flag |
| op_o | output | 3 | Bus operation class code |
| dq_o | output | DW (16) | Data pins, output side |
| dq_oe_o | output | 1 | Output enable for the data pin drivers |
| wr_valid_o | output | 1 | Single-cycle completed-write pulse |
| wr_addr_o | output | AW (23) | Address of the completed write |
| wr_data_o | output | DW (16) | Data of the completed write |
| lat_addr_o | output | AW (23) | Held address from the last address-valid release |
| abort_o | output | 1 | Single-cycle abort request to the program/erase engine |

## Verification
The assertions check on every cycle that the write and abort pulses last one clock and that no write record appears while code 0 is reported. They also check that an abort coincides with code 0, that a write record always follows a cycle classed as a write, and that standby is never reported while the engine was busy. The glitch threshold boundary needs bench scenarios, because only those can compare a two-sample pulse with a three-sample one. The same goes for the choice between the live and held address, which strobe ends a write, deferred standby, and the absence of an abort when the engine is idle.

// File: rtl/nbf_pkg.sv
package nbf_pkg;
  typedef enum logic [2:0] {
    OP_RESET   = 3'd0,
    OP_STANDBY = 3'd1,
    OP_READ    = 3'd2,
    OP_WRITE   = 3'd3,
    OP_ALATCH  = 3'd4,
    OP_ODIS    = 3'd5
  } bus_op_e;

  localparam int unsigned NUM_STROBES = 5;
  localparam int unsigned IDX_CE  = 0;
  localparam int unsigned IDX_OE  = 1;
  localparam int unsigned IDX_WE  = 2;
  localparam int unsigned IDX_ADV = 3;
  localparam int unsigned IDX_RST = 4;
endpackage

// File: rtl/nbf_strobe_cond.sv
module nbf_strobe_cond #(
  parameter int unsigned GLITCH      = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n_i,
  output logic strobe_n_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   level_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], strobe_n_i};
  end

  assign level_n = sync_q[SYNC_STAGES-1];

  generate
    if (GLITCH > 1) begin : g_filt
      localparam int unsigned     CW   = $clog2(GLITCH);
      localparam logic [CW-1:0]   CMAX = CW'(GLITCH - 1);
      logic [CW-1:0] cnt_q, cnt_d;
      logic          out_q, out_d;

      // release is immediate, assertion needs GLITCH consecutive low samples
      always_comb begin
        cnt_d = cnt_q;
        out_d = out_q;
        if (level_n) begin
          cnt_d = '0;
          out_d = 1'b1;
        end else if (cnt_q == CMAX) begin
          out_d = 1'b0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
          out_q <= 1'b1;
        end else begin
          cnt_q <= cnt_d;
          out_q <= out_d;
        end
      end

      assign strobe_n_o = out_q;
    end else begin : g_pass
      logic out_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= 1'b1;
        else        out_q <= level_n;
      end
      assign strobe_n_o = out_q;
    end
  endgenerate
endmodule

// File: rtl/nbf_classify.sv
module nbf_classify
  import nbf_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    ce_n,
  input  logic    oe_n,
  input  logic    we_n,
  input  logic    adv_n,
  input  logic    prst_n,
  input  logic    busy_i,
  output bus_op_e op_o,
  output logic    abort_o
);
  bus_op_e op_d, op_q;
  logic    prst_prev_q;
  logic    abort_d, abort_q;

  always_comb begin
    if (!prst_n)                 op_d = OP_RESET;
    else if (ce_n)               op_d = busy_i ? OP_ODIS : OP_STANDBY;
    else if (!we_n && oe_n)      op_d = OP_WRITE;
    else if (!oe_n && we_n)      op_d = OP_READ;
    else if (!adv_n && we_n)     op_d = OP_ALATCH;
    else                         op_d = OP_ODIS;
  end

  assign abort_d = !prst_n && prst_prev_q && busy_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q        <= OP_RESET;
      prst_prev_q <= 1'b1;
      abort_q     <= 1'b0;
    end else begin
      op_q        <= op_d;
      prst_prev_q <= prst_n;
      abort_q     <= abort_d;
    end
  end

  assign op_o    = op_q;
  assign abort_o = abort_q;
endmodule

// File: rtl/nbf_capture.sv
module nbf_capture #(
  parameter int unsigned AW = 23,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          adv_n,
  input  logic          prst_n,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] dq_i,
  output logic          wr_valid_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic [AW-1:0] lat_addr_o
);
  logic          write_phase, fire, adv_rise;
  logic          armed_q, adv_prev_q;
  logic [AW-1:0] lat_d, lat_q, wa_d, wa_q;
  logic [DW-1:0] wd_d, wd_q;
  logic          wv_q;

  assign write_phase = prst_n && !ce_n && !we_n && oe_n;
  // first of the two strobes to rise ends the write
  assign fire        = prst_n && armed_q && (ce_n || we_n);
  assign adv_rise    = prst_n && !ce_n && adv_n && !adv_prev_q;

  always_comb begin
    lat_d = lat_q;
    wa_d  = wa_q;
    wd_d  = wd_q;
    if (adv_rise) lat_d = addr_i;
    if (fire) begin
      wa_d = adv_n ? lat_q : addr_i;
      wd_d = dq_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q    <= 1'b0;
      adv_prev_q <= 1'b1;
      lat_q      <= '0;
      wa_q       <= '0;
      wd_q       <= '0;
      wv_q       <= 1'b0;
    end else begin
      armed_q    <= write_phase;
      adv_prev_q <= adv_n;
      lat_q      <= lat_d;
      wa_q       <= wa_d;
      wd_q       <= wd_d;
      wv_q       <= fire;
    end
  end

  assign wr_valid_o = wv_q;
  assign wr_addr_o  = wa_q;
  assign wr_data_o  = wd_q;
  assign lat_addr_o = lat_q;
endmodule

// File: rtl/nor_bus_front.sv
module nor_bus_front
  import nbf_pkg::*;
#(
  parameter int unsigned AW          = 23,
  parameter int unsigned DW          = 16,
  parameter int unsigned GLITCH      = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n_i,
  input  logic          oe_n_i,
  input  logic          we_n_i,
  input  logic          adv_n_i,
  input  logic          prst_n_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] dq_i,
  input  logic [DW-1:0] rd_data_i,
  input  logic          busy_i,
  output logic [2:0]    op_o,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o,
  output logic          wr_valid_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic [AW-1:0] lat_addr_o,
  output logic          abort_o
);
  logic [1:0]             rst_sync_q;
  logic                   rst_int_n;
  logic [NUM_STROBES-1:0] raw_n, cond_n;
  bus_op_e                op;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    raw_n          = '1;
    raw_n[IDX_CE]  = ce_n_i;
    raw_n[IDX_OE]  = oe_n_i;
    raw_n[IDX_WE]  = we_n_i;
    raw_n[IDX_ADV] = adv_n_i;
    raw_n[IDX_RST] = prst_n_i;
  end

  for (genvar i = 0; i < NUM_STROBES; i++) begin : g_strobe
    localparam int unsigned G_I = (i == IDX_CE || i == IDX_WE) ? GLITCH : 1;
    nbf_strobe_cond #(.GLITCH(G_I), .SYNC_STAGES(SYNC_STAGES)) u_cond (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .strobe_n_i (raw_n[i]),
      .strobe_n_o (cond_n[i])
    );
  end

  nbf_classify u_class (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .ce_n    (cond_n[IDX_CE]),
    .oe_n    (cond_n[IDX_OE]),
    .we_n    (cond_n[IDX_WE]),
    .adv_n   (cond_n[IDX_ADV]),
    .prst_n  (cond_n[IDX_RST]),
    .busy_i  (busy_i),
    .op_o    (op),
    .abort_o (abort_o)
  );

  nbf_capture #(.AW(AW), .DW(DW)) u_cap (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .ce_n       (cond_n[IDX_CE]),
    .oe_n       (cond_n[IDX_OE]),
    .we_n       (cond_n[IDX_WE]),
    .adv_n      (cond_n[IDX_ADV]),
    .prst_n     (cond_n[IDX_RST]),
    .addr_i     (addr_i),
    .dq_i       (dq_i),
    .wr_valid_o (wr_valid_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o),
    .lat_addr_o (lat_addr_o)
  );

  assign op_o    = op;
  assign dq_oe_o = (op == OP_READ);
  assign dq_o    = dq_oe_o ? rd_data_i : '0;
endmodule

// File: rtl/nor_bus_front_chk.sv
module nor_bus_front_chk
  import nbf_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] op_o,
  input logic       wr_valid_o,
  input logic       abort_o,
  input logic       busy_i
);
  // R11
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |=> !wr_valid_o);

  // R10
  abort_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> !abort_o);

  // R10
  abort_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> (op_o == 3'(OP_RESET)));

  // R5
  no_write_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_o == 3'(OP_RESET)) |-> !wr_valid_o);

  // R7
  wr_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> ($past(op_o) == 3'(OP_WRITE)));

  // R4
  standby_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_o == 3'(OP_STANDBY)) |-> !$past(busy_i));
endmodule

bind nor_bus_front nor_bus_front_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_o       (op_o),
  .wr_valid_o (wr_valid_o),
  .abort_o    (abort_o),
  .busy_i     (busy_i)
);

// File: tb/nor_bus_front_test.sv
module nor_bus_front_test;
  localparam int AW = 23, DW = 16, HOLD = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, ce_n, oe_n, we_n, adv_n, prst_n, busy;
  logic [AW-1:0] addr;
  logic [DW-1:0] dq_in, rd_data;
  logic [2:0]    op;
  logic [DW-1:0] dq_o;
  logic          dq_oe, wr_valid, abort;
  logic [AW-1:0] wr_addr, lat_addr;
  logic [DW-1:0] wr_data;

  int n_chk = 0, n_bad = 0, wr_cnt = 0, ab_cnt = 0;
  logic [AW-1:0] cap_addr, model_lat;
  logic [DW-1:0] cap_data;

  nor_bus_front uut (
    .clk(clk), .rst_n(rst_n), .ce_n_i(ce_n), .oe_n_i(oe_n), .we_n_i(we_n),
    .adv_n_i(adv_n), .prst_n_i(prst_n), .addr_i(addr), .dq_i(dq_in),
    .rd_data_i(rd_data), .busy_i(busy), .op_o(op), .dq_o(dq_o), .dq_oe_o(dq_oe),
    .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .lat_addr_o(lat_addr), .abort_o(abort)
  );

  always @(negedge clk) begin
    if (wr_valid) begin
      wr_cnt++;
      cap_addr = wr_addr;
      cap_data = wr_data;
    end
    if (abort) ab_cnt++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle();
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; adv_n = 1'b1; prst_n = 1'b1;
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  function automatic logic [AW-1:0] exp_wr_addr(input bit use_adv, input logic [AW-1:0] a);
    return use_adv ? a : model_lat;
  endfunction

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input bit use_adv, input bit via_ce);
    int base;
    logic [AW-1:0] ea;
    ea = exp_wr_addr(use_adv, a);
    step(1);
    ce_n = 1'b0; addr = a; dq_in = d;
    if (use_adv) adv_n = 1'b0;
    step(HOLD);
    we_n = 1'b0;
    step(HOLD);
    chk("R1 write class", 32'(op), 32'd3);
    base = wr_cnt;
    if (via_ce) ce_n = 1'b1; else we_n = 1'b1;
    step(HOLD);
    if (via_ce) begin
      adv_n = 1'b1; we_n = 1'b1;
    end else begin
      adv_n = 1'b1;
      step(HOLD);
      ce_n = 1'b1;
    end
    step(HOLD);
    chk(via_ce ? "R7 pulse count (cs first)" : "R7 pulse count (we first)", 32'(wr_cnt - base), 32'd1);
    chk("R7 write data", 32'(cap_data), 32'(d));
    chk("R8 write address", 32'(cap_addr), 32'(ea));
    if (use_adv && !via_ce) model_lat = a;
  endtask

  task automatic do_latch(input logic [AW-1:0] a);
    step(1);
    ce_n = 1'b0; adv_n = 1'b0; addr = a;
    step(HOLD);
    chk("R1 latch class", 32'(op), 32'd4);
    adv_n = 1'b1;
    step(HOLD);
    ce_n = 1'b1;
    addr = ~a;
    model_lat = a;
    step(HOLD);
    chk("R6 held address", 32'(lat_addr), 32'(a));
  endtask

  task automatic do_read(input logic [DW-1:0] d);
    step(1);
    rd_data = d; ce_n = 1'b0; oe_n = 1'b0;
    step(HOLD);
    chk("R1 read class", 32'(op), 32'd2);
    chk("R2 drive enable", 32'(dq_oe), 32'd1);
    chk("R2 read data", 32'(dq_o), 32'(d));
    oe_n = 1'b1;
    step(HOLD);
    chk("R3 no drive with oe high", 32'(dq_oe), 32'd0);
    chk("R1 output disable class", 32'(op), 32'd5);
    ce_n = 1'b1;
    step(HOLD);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int base;
    void'($urandom(32'd20241));
    rst_n = 1'b0; busy = 1'b0; addr = '0; dq_in = '0; rd_data = '0;
    model_lat = '0; cap_addr = '0; cap_data = '0;
    idle();
    step(3);
    // R12 quiet outputs during system reset
    chk("R12 op in reset", 32'(op), 32'd0);
    chk("R12 dq_oe in reset", 32'(dq_oe), 32'd0);
    chk("R12 wr_valid in reset", 32'(wr_valid), 32'd0);
    chk("R12 abort in reset", 32'(abort), 32'd0);
    rst_n = 1'b1;
    step(HOLD);
    chk("R4 standby idle", 32'(op), 32'd1);

    // directed: address latch then write using held address
    do_latch(23'h2A5A5A);
    do_write(23'h000111, 16'hBEEF, 1'b0, 1'b0);
    do_write(23'h123456, 16'h1234, 1'b1, 1'b0);
    do_write(23'h654321, 16'hA5A5, 1'b1, 1'b1);
    do_read(16'hC3C3);

    // R9 glitch on write strobe (2 samples) -> nothing
    step(1);
    ce_n = 1'b0; dq_in = 16'h0F0F;
    step(HOLD);
    base = wr_cnt;
    we_n = 1'b0; step(2); we_n = 1'b1;
    step(HOLD);
    ce_n = 1'b1;
    step(HOLD);
    chk("R9 short we pulse ignored", 32'(wr_cnt - base), 32'd0);

    // R9 glitch on chip select with write strobe held low
    we_n = 1'b0;
    step(HOLD);
    base = wr_cnt;
    ce_n = 1'b0; step(2); ce_n = 1'b1;
    step(HOLD);
    we_n = 1'b1;
    step(HOLD);
    chk("R9 short cs pulse ignored", 32'(wr_cnt - base), 32'd0);

    // R9 boundary: exactly GLITCH samples counts
    ce_n = 1'b0; dq_in = 16'h7E57;
    step(HOLD);
    base = wr_cnt;
    we_n = 1'b0; step(3); we_n = 1'b1;
    step(HOLD);
    ce_n = 1'b1;
    step(HOLD);
    chk("R9 threshold pulse writes", 32'(wr_cnt - base), 32'd1);
    chk("R9 threshold pulse data", 32'(cap_data), 32'h7E57);

    // R4 deferred standby
    busy = 1'b1;
    step(HOLD);
    chk("R4 busy keeps code 5", 32'(op), 32'd5);
    chk("R4 no drive while busy", 32'(dq_oe), 32'd0);
    busy = 1'b0;
    step(HOLD);
    chk("R4 standby after busy", 32'(op), 32'd1);

    // R5 / R10 pin reset during busy read
    busy = 1'b1; ce_n = 1'b0; oe_n = 1'b0; rd_data = 16'h5555;
    step(HOLD);
    base = ab_cnt;
    prst_n = 1'b0;
    step(HOLD);
    chk("R10 abort on busy reset", 32'(ab_cnt - base), 32'd1);
    chk("R5 reset class", 32'(op), 32'd0);
    chk("R5 reset no drive", 32'(dq_oe), 32'd0);
    oe_n = 1'b1;
    base = wr_cnt;
    we_n = 1'b0; step(HOLD); we_n = 1'b1;
    step(HOLD);
    chk("R5 no write in reset", 32'(wr_cnt - base), 32'd0);
    idle();
    busy = 1'b0;
    step(HOLD);
    base = ab_cnt;
    prst_n = 1'b0;
    step(HOLD);
    chk("R10 no abort when idle", 32'(ab_cnt - base), 32'd0);
    prst_n = 1'b1;
    step(HOLD);

    // random mix
    for (int k = 0; k < 30; k++) begin
      int sel;
      sel = int'($urandom % 3);
      if (sel == 0)
        do_write(AW'($urandom), DW'($urandom), bit'($urandom % 2), bit'($urandom % 2));
      else if (sel == 1)
        do_read(DW'($urandom));
      else
        do_latch(AW'($urandom));
    end

    report();
  end
endmodule